// File: doc/BRIEF.md
# Clock Post-Divider with Stepped Power-Down

This block divides a fast input clock by a power of two chosen with a small ratio code. The four codes give divide by 1, 2, 4 or 8, and the output keeps an even duty cycle at every ratio. At divide by 1 the input clock passes straight through with its phase unchanged. A ratio change takes effect only at the end of an output period, while the output is low, so the output never carries a short pulse.

A power-down request does not stop the output. Instead it adds an extra division stage that moves by one factor of two on each rising edge of a separate, slower reference clock. While the request is held, the extra division climbs from 1 through 2, 4 and 8 to 16 and then holds. When the request is released, the extra division falls back to 1 over four reference edges. The direction of each step is set by the request level when the reference edge arrives. The reference step and the request are each brought into the fast domain through a two-flop synchroniser.

Top module: `postdiv_pd`

## Requirements
- R1: With no extra division, ratio code c (00, 01, 10, 11) gives an output period of 2^c fast-clock cycles.
- R2: For any total ratio D of 2 or more, the output is high for D/2 fast cycles and low for D/2 fast cycles.
- R3: With code 00 and no extra division, the output is high in every high phase of the fast clock and low in every low phase.
- R4: While power-down is asserted, each reference-clock rising edge doubles the extra division (2, 4, 8, 16), so the period becomes 2^(c+k) after k edges.
- R5: The extra division saturates at 16; further reference edges with power-down asserted leave the period at 2^(c+4).
- R6: After power-down is released, each reference edge halves the extra division, and the programmed period returns after four edges and then stays.
- R7: Without reference-clock edges the extra division does not change, whatever the power-down level.
- R8: The step direction follows the power-down level at each reference edge, so releasing it part-way reverses the walk from the current stage.
- R9: Every output high pulse lasts either half a fast cycle (pass-through) or 2^k fast cycles for some k from 0 to 6, including across ratio and stage changes.
- R10: The output is low during reset; reset clears the extra division to 1, and after release the first output rise comes on the D/2-th fast rising edge at which reset is seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock to be divided |
| clk_ref | input | 1 | Slow clock that paces power-down steps |
| rst | input | 1 | Synchronous active-high reset, sampled on both clocks |
| ratio_sel | input | CODE_W | Ratio code; divide by 2^code |
| pwr_dn | input | 1 | Power-down request, asynchronous to clk_fast |
| clk_out | output | 1 | Divided clock |

## Verification
A reference edge reaches the stage register after the two synchroniser flops and one edge-detect flop. It then waits for the current output period to end, which can take up to 128 fast cycles, so the bench lets 400 fast cycles pass after every change before it measures. Periods are measured from a sampled output rise, with samples taken 1 ns after each fast rising edge, and pass-through is also sampled in the low phase. After reset the first rise is due on the D/2-th sampled edge, and the bench counts edges from the release to that point. A monitor times every high pulse of the whole run against the allowed widths.

// File: rtl/pdiv_pkg.sv
`timescale 1ns/1ps
package pdiv_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_dir_t;

  // largest total division exponent for a code width and stage count
  function automatic int exp_top(int code_w, int stages);
    return (1 << code_w) - 1 + stages;
  endfunction
endpackage

// File: rtl/pdiv_sync.sv
`timescale 1ns/1ps
module pdiv_sync #(
  parameter int W     = 2,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [DEPTH-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[DEPTH-2:0], d};
  end

  assign q = chain[DEPTH-1];
endmodule

// File: rtl/pdiv_ref_tick.sv
`timescale 1ns/1ps
module pdiv_ref_tick (
  input  logic clk_ref,
  input  logic rst,
  output logic tick_tog
);
  // one toggle per reference edge; the fast side detects the change
  always_ff @(posedge clk_ref) begin
    if (rst) tick_tog <= 1'b0;
    else     tick_tog <= ~tick_tog;
  end
endmodule

// File: rtl/pdiv_stage_ctl.sv
`timescale 1ns/1ps
module pdiv_stage_ctl
  import pdiv_pkg::*;
#(
  parameter int STAGES = 4,
  localparam int SW    = $clog2(STAGES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tog_s,
  input  logic          pd_s,
  output logic          step,
  output logic [SW-1:0] stage
);
  logic      tog_d;
  step_dir_t dir;

  assign step = tog_s ^ tog_d;

  always_comb begin
    if (!step)     dir = STEP_HOLD;
    else if (pd_s) dir = STEP_UP;
    else           dir = STEP_DOWN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tog_d <= 1'b0;
      stage <= '0;
    end else begin
      tog_d <= tog_s;
      case (dir)
        STEP_UP:   if (stage != SW'(STAGES)) stage <= stage + SW'(1);
        STEP_DOWN: if (stage != '0)          stage <= stage - SW'(1);
        default:   stage <= stage;
      endcase
    end
  end
endmodule

// File: rtl/pdiv_core.sv
`timescale 1ns/1ps
module pdiv_core #(
  parameter int EW = 3,
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [EW-1:0] e_req,
  output logic          clk_out,
  output logic [EW-1:0] e_cur,
  output logic [CW-1:0] cnt,
  output logic          div_q,
  output logic          pass_en
);
  logic [CW:0]   pow_e;
  logic [CW-1:0] lim;
  logic [CW-1:0] half;
  logic [CW-1:0] cnt_nx;
  logic          pass_q;

  always_comb begin
    pow_e  = (CW + 1)'(1) << e_cur;
    lim    = pow_e[CW-1:0] - CW'(1);
    half   = pow_e[CW:1];
    cnt_nx = cnt + CW'(1);
  end

  // period counter; the ratio is reloaded only at the period boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      e_cur  <= e_req;
      div_q  <= 1'b0;
      pass_q <= 1'b0;
    end else if (cnt == lim) begin
      cnt    <= '0;
      e_cur  <= e_req;
      div_q  <= 1'b0;
      pass_q <= (e_req == '0);
    end else begin
      cnt    <= cnt_nx;
      div_q  <= (cnt_nx >= half);
    end
  end

  // pass-through enable moves only while the fast clock is low
  always_ff @(negedge clk) begin
    if (rst) pass_en <= 1'b0;
    else     pass_en <= pass_q;
  end

  assign clk_out = pass_en ? clk : div_q;
endmodule

// File: rtl/postdiv_pd.sv
`timescale 1ns/1ps
module postdiv_pd #(
  parameter int CODE_W     = 2,
  parameter int STAGES     = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk_fast,
  input  logic              clk_ref,
  input  logic              rst,
  input  logic [CODE_W-1:0] ratio_sel,
  input  logic              pwr_dn,
  output logic              clk_out
);
  localparam int EXP_MAX = pdiv_pkg::exp_top(CODE_W, STAGES);
  localparam int EW      = $clog2(EXP_MAX + 1);
  localparam int CW      = EXP_MAX;
  localparam int SW      = $clog2(STAGES + 1);

  logic          tick_tog;
  logic [1:0]    sync_q;
  logic          step_p;
  logic [SW-1:0] stage_q;
  logic [EW-1:0] e_req;
  logic [EW-1:0] e_cur;
  logic [CW-1:0] cnt_q;
  logic          div_q;
  logic          pass_en;

  pdiv_ref_tick u_tick (
    .clk_ref  (clk_ref),
    .rst      (rst),
    .tick_tog (tick_tog)
  );

  pdiv_sync #(.W(2), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk (clk_fast),
    .rst (rst),
    .d   ({pwr_dn, tick_tog}),
    .q   (sync_q)
  );

  pdiv_stage_ctl #(.STAGES(STAGES)) u_stage (
    .clk   (clk_fast),
    .rst   (rst),
    .tog_s (sync_q[0]),
    .pd_s  (sync_q[1]),
    .step  (step_p),
    .stage (stage_q)
  );

  assign e_req = EW'(ratio_sel) + EW'(stage_q);

  pdiv_core #(.EW(EW), .CW(CW)) u_core (
    .clk     (clk_fast),
    .rst     (rst),
    .e_req   (e_req),
    .clk_out (clk_out),
    .e_cur   (e_cur),
    .cnt     (cnt_q),
    .div_q   (div_q),
    .pass_en (pass_en)
  );
endmodule

// File: rtl/pdiv_chk.sv
`timescale 1ns/1ps
module pdiv_chk #(
  parameter int CODE_W = 2,
  parameter int STAGES = 4,
  localparam int EXP_MAX = pdiv_pkg::exp_top(CODE_W, STAGES),
  localparam int EW = $clog2(EXP_MAX + 1),
  localparam int CW = EXP_MAX,
  localparam int SW = $clog2(STAGES + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic [SW-1:0] stage,
  input logic          step,
  input logic [EW-1:0] e_cur,
  input logic [CW-1:0] cnt,
  input logic          div_q,
  input logic          pass_en
);
  // R5
  stage_cap_chk: assert property (@(posedge clk) disable iff (rst)
    stage <= SW'(STAGES));

  // R4 R6
  stage_unit_chk: assert property (@(posedge clk) disable iff (rst)
    (stage != $past(stage)) |->
      (stage == $past(stage) + SW'(1) || $past(stage) == stage + SW'(1)));

  // R7
  stage_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(stage));

  // R9
  ratio_low_chk: assert property (@(posedge clk) disable iff (rst)
    (e_cur != $past(e_cur)) |-> !div_q);

  // R2
  wrap_low_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) |-> !div_q);

  // R3
  pass_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    pass_en |-> !div_q);
endmodule

bind postdiv_pd pdiv_chk #(.CODE_W(CODE_W), .STAGES(STAGES)) u_chk (
  .clk     (clk_fast),
  .rst     (rst),
  .stage   (stage_q),
  .step    (step_p),
  .e_cur   (e_cur),
  .cnt     (cnt_q),
  .div_q   (div_q),
  .pass_en (pass_en)
);

// File: tb/tb_postdiv_pd.sv
`timescale 1ns/1ps
module tb_postdiv_pd;
  logic       clk_fast = 1'b0;
  logic       clk_ref  = 1'b0;
  logic       rst      = 1'b1;
  logic [1:0] ratio_sel = 2'd3;
  logic       pwr_dn   = 1'b0;
  logic       clk_out;

  int  n_chk = 0;
  int  n_bad = 0;
  int  cyc   = 0;
  int  runts = 0;
  int  pulses = 0;
  bit  mon   = 1'b0;
  bit  done  = 1'b0;
  realtime t_rise = 0.0;
  int  w_ps;

  postdiv_pd dut (
    .clk_fast  (clk_fast),
    .clk_ref   (clk_ref),
    .rst       (rst),
    .ratio_sel (ratio_sel),
    .pwr_dn    (pwr_dn),
    .clk_out   (clk_out)
  );

  always #2 clk_fast = ~clk_fast;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk_fast) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected below 150000", cyc);
      summary();
      $finish;
    end
  end

  // R9: high pulse width monitor
  always @(posedge clk_out) t_rise = $realtime;
  always @(negedge clk_out) begin
    if (mon) begin
      w_ps = int'(($realtime - t_rise) * 1000.0);
      pulses++;
      if (!(w_ps == 2000 || (w_ps % 4000 == 0 && w_ps >= 4000 && w_ps <= 256000 &&
            (((w_ps / 4000) & ((w_ps / 4000) - 1)) == 0))))
        runts++;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic ref_tick();
    #7 clk_ref = 1'b1;
    #13 clk_ref = 1'b0;
  endtask

  task automatic wait_fast(int n);
    repeat (n) @(posedge clk_fast);
  endtask

  task automatic samp(output bit v);
    @(posedge clk_fast);
    #1 v = clk_out;
  endtask

  task automatic settle();
    wait_fast(400);
  endtask

  task automatic measure(int d, string req);
    bit prev, cur;
    int h, l;
    if (d == 1) begin
      h = 0; l = 0;
      for (int i = 0; i < 8; i++) begin
        @(posedge clk_fast);
        #1 if (clk_out) h++;
        #2 if (!clk_out) l++;
      end
      check(h == 8 && l == 8, req, "pass-through phase samples", h + l, 16);
    end else begin
      samp(prev);
      for (int i = 0; i < 400; i++) begin
        samp(cur);
        if (!prev && cur) break;
        prev = cur;
      end
      h = 1;
      samp(cur);
      while (cur) begin h++; samp(cur); end
      l = 1;
      samp(cur);
      while (!cur) begin l++; samp(cur); end
      check(h + l == d, req, "period in fast cycles", h + l, d);
      check(h == d / 2, "R2", "high cycles", h, d / 2);
    end
  endtask

  initial begin
    bit v;
    int lows;
    // R10: reset behaviour with code 11 (divide by 8)
    ref_tick();
    wait_fast(5);
    samp(v);
    check(v == 1'b0, "R10", "output during reset", v, 0);
    @(posedge clk_fast);
    #1 rst = 1'b0;
    lows = 0;
    for (int i = 0; i < 3; i++) begin samp(v); if (!v) lows++; end
    check(lows == 3, "R10", "low samples before first rise", lows, 3);
    samp(v);
    check(v == 1'b1, "R10", "first rise on 4th edge", v, 1);
    wait_fast(20);
    mon = 1'b1;

    for (int c = 0; c < 4; c++) begin
      ratio_sel = 2'(c);
      pwr_dn = 1'b0;
      settle();
      measure(1 << c, (c == 0) ? "R3" : "R1");
      // R7: request alone, no reference edge
      pwr_dn = 1'b1;
      settle();
      measure(1 << c, "R7");
      // R4: step up
      for (int k = 1; k <= 4; k++) begin
        ref_tick();
        settle();
        measure(1 << (c + k), "R4");
      end
      // R5: saturation
      ref_tick();
      ref_tick();
      settle();
      measure(1 << (c + 4), "R5");
      // R6: step back down
      pwr_dn = 1'b0;
      for (int k = 3; k >= 0; k--) begin
        ref_tick();
        settle();
        measure(1 << (c + k), "R6");
      end
      ref_tick();
      settle();
      measure(1 << c, "R6");
    end

    // R8: reversal part-way
    ratio_sel = 2'd1;
    pwr_dn = 1'b1;
    ref_tick();
    ref_tick();
    settle();
    measure(8, "R8");
    pwr_dn = 1'b0;
    ref_tick();
    settle();
    measure(4, "R8");
    pwr_dn = 1'b1;
    ref_tick();
    settle();
    measure(8, "R8");

    // R9: pulse widths over the whole run
    check(runts == 0, "R9", "high pulses of illegal width", runts, 0);
    check(pulses > 0, "R9", "high pulses observed", (pulses > 0) ? 1 : 0, 1);

    // R10: reset clears the extra division
    mon = 1'b0;
    pwr_dn = 1'b0;
    @(posedge clk_fast);
    #1 rst = 1'b1;
    ref_tick();
    wait_fast(5);
    @(posedge clk_fast);
    #1 rst = 1'b0;
    settle();
    measure(2, "R10");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule